// File: doc/BRIEF.md
# Serial MII Segment Gasket

This block sits between up to four 10/100 Ethernet MAC ports and a serial PHY-side link in which each port owns one transmit wire and one receive wire. A clock and a segment-start marker (`smii_sync`) are shared by all ports. Every ten clocks, one 10-bit segment crosses each wire in each direction, and the first bit of each segment lines up with the sync pulse on every port.

On the transmit side, each MAC hands over a byte as two 4-bit nibbles, low nibble first. The gasket packs the error flag, the enable flag and the byte into a segment. It moves a new segment into the shifter only at a segment boundary. On the receive side, it splits each incoming segment into carrier sense, data valid and the data byte, and passes the byte to the MAC as two nibble strobes.

In 10 Mb/s mode (`slow_mode` high), one byte fills ten consecutive segments. The transmitter takes new content only on every tenth boundary. The receiver accepts only every tenth segment and discards the repeats.

Three kinds of state machine control the block. There is one shared sequencer and, for each port, one transmit nibble assembler and one receive nibble presenter.

- The sequencer has three states: SQ_IDLE, SQ_SYNC and SQ_BITS. SQ_IDLE is held in reset and goes to SQ_SYNC on the first clock after reset. SQ_SYNC always goes to SQ_BITS. SQ_BITS stays in place for bits 1 to 8 and returns to SQ_SYNC after bit 9.
- The assembler has two states. It goes from TXA_LOW to TXA_HIGH on a nibble strobe. It goes back to TXA_LOW on the next strobe, and that strobe completes a byte.
- The presenter has two states. It goes from RXO_IDLE to RXO_HIGH when it accepts a segment whose data-valid bit is set. It goes back to RXO_IDLE after one cycle.

Top module: `smii_gasket`

## Requirements
- R1: While reset is held and in the single cycle after it is released, `smii_sync`, every `smii_tx` line, `rx_nib_vld`, `rx_crs` and `rx_dv` are low. The first `smii_sync` pulse appears in the cycle after the first clock edge with reset released.
- R2: `smii_sync` is high for exactly one cycle out of every 10, and that cycle carries bit 0 of the segment on all ports.
- R3: A transmit segment leaves bit 0 first, in the sync cycle. Bit 0 is the error flag, bit 1 is the enable flag, and bits 2 to 9 are data bits 0 to 7.
- R4: On `tx_nib_stb`, the first nibble is data bits 3:0 and the second is bits 7:4. The enable flag is taken with the second nibble. The error flag is the OR of both nibbles' `tx_er`. The byte goes out in the segment that starts at the next boundary where new content is taken. A byte that completes while an earlier one is still waiting replaces the earlier one.
- R5: At a boundary where new content is taken and no byte is waiting, the port sends an all-zero segment.
- R6: For an accepted receive segment, bit 0 is reported on `rx_crs`, bit 1 on `rx_dv`, and bits 2 to 9 are data bits 0 to 7. Both outputs update at the clock edge that ends the segment and hold until the next accepted segment.
- R7: An accepted segment with data valid set gives `rx_nib_vld` high for exactly two cycles, starting in the next sync cycle: data bits 3:0 first, then bits 7:4.
- R8: An accepted segment with data valid clear passes no nibbles (`rx_nib_vld` stays low) and drives `rx_dv` low, while still updating `rx_crs`.
- R9: In 10 Mb/s mode, a transmit segment is repeated over 10 consecutive segments. New content is taken only on boundaries 0, 10, 20, and so on, counted from the first sync after reset.
- R10: In 10 Mb/s mode, only received segments 0, 10, 20, and so on after reset are accepted. The segments in between leave `rx_crs`, `rx_dv` and `rx_nib_vld` unchanged.
- R11: Ports are independent. Each port's lines and MAC signals carry only that port's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | 1 = 10 Mb/s (tenfold segment repeat), 0 = 100 Mb/s |
| smii_sync | output | 1 | Segment-start marker shared by all ports |
| tx_nib_stb | input | NUM_PORTS | Per-port nibble strobe from the MAC |
| tx_nib | input | 4*NUM_PORTS | Per-port transmit nibble, port p at bits 4p+3:4p |
| tx_en | input | NUM_PORTS | Per-port transmit enable, taken with the high nibble |
| tx_er | input | NUM_PORTS | Per-port transmit error, ORed over both nibbles |
| smii_tx | output | NUM_PORTS | Per-port serial transmit line |
| smii_rx | input | NUM_PORTS | Per-port serial receive line |
| rx_crs | output | NUM_PORTS | Carrier sense from the last accepted segment |
| rx_dv | output | NUM_PORTS | Data valid from the last accepted segment |
| rx_nib_vld | output | NUM_PORTS | Receive nibble strobe |
| rx_nib | output | 4*NUM_PORTS | Per-port receive nibble, port p at bits 4p+3:4p |

## Verification
The hardest behaviour to reach from the ports is the 10 Mb/s repeat phase. Whether a boundary takes new content depends on a count that is never visible outside the block. The bench reaches this phase by resetting into slow mode and counting segments from the first sync. It feeds a byte in segment 0, which is then held back until boundary 10. It offers two bytes to a second port before that boundary, so that replacement is exercised. On the receive side it sends nine differing repeats after an accepted segment and shows that the nibble strobes and flags ignore them.

// File: rtl/smii_gasket_pkg.sv
package smii_gasket_pkg;
    localparam int SEG_BITS = 10;
    localparam int NIB_W    = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SYNC,
        SQ_BITS
    } seq_state_e;

    typedef enum logic {
        TXA_LOW,
        TXA_HIGH
    } txa_state_e;

    typedef enum logic {
        RXO_IDLE,
        RXO_HIGH
    } rxo_state_e;
endpackage

// File: rtl/smii_gasket_seq.sv
module smii_gasket_seq
    import smii_gasket_pkg::*;
#(
    parameter int SLOW_REPEAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_mode,
    output logic sync,
    output logic load_stb,
    output logic seg_end,
    output logic shift_en,
    output logic tx_fresh,
    output logic rx_fresh
);
    localparam int CNT_W = $clog2(SEG_BITS);
    localparam int REP_W = (SLOW_REPEAT > 1) ? $clog2(SLOW_REPEAT) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SEG_BITS - 1);
    localparam logic [REP_W-1:0] LAST_REP = REP_W'(SLOW_REPEAT - 1);

    seq_state_e       state, state_n;
    logic [CNT_W-1:0] bit_cnt, bit_cnt_n;
    logic [REP_W-1:0] tx_rep, rx_rep;

    // next-state logic
    always_comb begin
        state_n   = state;
        bit_cnt_n = bit_cnt;
        unique case (state)
            SQ_IDLE: begin
                state_n   = SQ_SYNC;
                bit_cnt_n = '0;
            end
            SQ_SYNC: begin
                state_n   = SQ_BITS;
                bit_cnt_n = CNT_W'(1);
            end
            SQ_BITS: begin
                if (bit_cnt == LAST_BIT) begin
                    state_n   = SQ_SYNC;
                    bit_cnt_n = '0;
                end else begin
                    bit_cnt_n = bit_cnt + CNT_W'(1);
                end
            end
            default: begin
                state_n   = SQ_IDLE;
                bit_cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            bit_cnt <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_cnt_n;
        end
    end

    // outputs
    always_comb begin
        sync     = (state == SQ_SYNC);
        load_stb = (state_n == SQ_SYNC);
        seg_end  = (state == SQ_BITS) && (bit_cnt == LAST_BIT);
        shift_en = (state != SQ_IDLE);
        tx_fresh = !slow_mode || (tx_rep == '0);
        rx_fresh = !slow_mode || (rx_rep == '0);
    end

    // repeat phase counters for 10 Mb/s operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_rep <= '0;
            rx_rep <= '0;
        end else begin
            if (load_stb) begin
                tx_rep <= (slow_mode && tx_rep != LAST_REP) ? tx_rep + REP_W'(1) : '0;
            end
            if (seg_end) begin
                rx_rep <= (slow_mode && rx_rep != LAST_REP) ? rx_rep + REP_W'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/smii_gasket_tx_lane.sv
module smii_gasket_tx_lane
    import smii_gasket_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_stb,
    input  logic [NIB_W-1:0] nib,
    input  logic             mac_en,
    input  logic             mac_er,
    input  logic             load_stb,
    input  logic             fresh,
    output logic             line
);
    txa_state_e            st, st_n;
    logic                  complete;
    logic                  take;
    logic [NIB_W-1:0]      lo_nib;
    logic                  lo_er;
    logic                  pend_vld;
    logic [SEG_BITS-1:0]   new_seg, pend_seg, hold_seg, shreg, next_seg;

    // nibble assembler transitions
    always_comb begin
        st_n     = st;
        complete = 1'b0;
        unique case (st)
            TXA_LOW: begin
                if (nib_stb) st_n = TXA_HIGH;
            end
            TXA_HIGH: begin
                if (nib_stb) begin
                    st_n     = TXA_LOW;
                    complete = 1'b1;
                end
            end
            default: st_n = TXA_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TXA_LOW;
        else        st <= st_n;
    end

    // segment layout: [0]=error, [1]=enable, [9:2]=data bits 0..7
    always_comb begin
        new_seg  = {nib, lo_nib, mac_en, mac_er | lo_er};
        take     = load_stb && fresh;
        next_seg = pend_vld ? pend_seg : '0;
        line     = shreg[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_nib   <= '0;
            lo_er    <= 1'b0;
            pend_vld <= 1'b0;
            pend_seg <= '0;
            hold_seg <= '0;
            shreg    <= '0;
        end else begin
            if (st == TXA_LOW && nib_stb) begin
                lo_nib <= nib;
                lo_er  <= mac_er;
            end
            if (take) begin
                hold_seg <= next_seg;
                shreg    <= next_seg;
            end else if (load_stb) begin
                shreg <= hold_seg;
            end else begin
                shreg <= shreg >> 1;
            end
            if (complete) begin
                pend_vld <= 1'b1;
                pend_seg <= new_seg;
            end else if (take) begin
                pend_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smii_gasket_rx_lane.sv
module smii_gasket_rx_lane
    import smii_gasket_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             shift_en,
    input  logic             seg_end,
    input  logic             fresh,
    output logic             crs,
    output logic             dv,
    output logic             nib_vld,
    output logic [NIB_W-1:0] nib
);
    rxo_state_e          st, st_n;
    logic [SEG_BITS-2:0] rx_sh;
    logic [SEG_BITS-1:0] full;
    logic [NIB_W-1:0]    hi_nib;
    logic                accept;

    always_comb begin
        full   = {line, rx_sh};
        accept = seg_end && fresh;
    end

    // presenter transitions
    always_comb begin
        st_n = st;
        unique case (st)
            RXO_IDLE: begin
                if (accept && full[1]) st_n = RXO_HIGH;
            end
            RXO_HIGH: st_n = RXO_IDLE;
            default:  st_n = RXO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RXO_IDLE;
        else        st <= st_n;
    end

    // deserializer and captured flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh  <= '0;
            crs    <= 1'b0;
            dv     <= 1'b0;
            hi_nib <= '0;
        end else begin
            if (shift_en) rx_sh <= full[SEG_BITS-1:1];
            if (accept) begin
                crs    <= full[0];
                dv     <= full[1];
                hi_nib <= full[9:6];
            end
        end
    end

    // MAC-side nibble outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_vld <= 1'b0;
            nib     <= '0;
        end else begin
            unique case (st)
                RXO_IDLE: begin
                    if (accept && full[1]) begin
                        nib_vld <= 1'b1;
                        nib     <= full[5:2];
                    end else begin
                        nib_vld <= 1'b0;
                    end
                end
                RXO_HIGH: begin
                    nib_vld <= 1'b1;
                    nib     <= hi_nib;
                end
                default: nib_vld <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smii_gasket.sv
module smii_gasket
    import smii_gasket_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int SLOW_REPEAT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slow_mode,
    output logic                       smii_sync,
    input  logic [NUM_PORTS-1:0]       tx_nib_stb,
    input  logic [NUM_PORTS*NIB_W-1:0] tx_nib,
    input  logic [NUM_PORTS-1:0]       tx_en,
    input  logic [NUM_PORTS-1:0]       tx_er,
    output logic [NUM_PORTS-1:0]       smii_tx,
    input  logic [NUM_PORTS-1:0]       smii_rx,
    output logic [NUM_PORTS-1:0]       rx_crs,
    output logic [NUM_PORTS-1:0]       rx_dv,
    output logic [NUM_PORTS-1:0]       rx_nib_vld,
    output logic [NUM_PORTS*NIB_W-1:0] rx_nib
);
    logic load_stb, seg_end, shift_en, tx_fresh, rx_fresh;

    smii_gasket_seq #(
        .SLOW_REPEAT(SLOW_REPEAT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_mode(slow_mode),
        .sync     (smii_sync),
        .load_stb (load_stb),
        .seg_end  (seg_end),
        .shift_en (shift_en),
        .tx_fresh (tx_fresh),
        .rx_fresh (rx_fresh)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        smii_gasket_tx_lane u_tx (
            .clk     (clk),
            .rst_n   (rst_n),
            .nib_stb (tx_nib_stb[p]),
            .nib     (tx_nib[p*NIB_W +: NIB_W]),
            .mac_en  (tx_en[p]),
            .mac_er  (tx_er[p]),
            .load_stb(load_stb),
            .fresh   (tx_fresh),
            .line    (smii_tx[p])
        );

        smii_gasket_rx_lane u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .line    (smii_rx[p]),
            .shift_en(shift_en),
            .seg_end (seg_end),
            .fresh   (rx_fresh),
            .crs     (rx_crs[p]),
            .dv      (rx_dv[p]),
            .nib_vld (rx_nib_vld[p]),
            .nib     (rx_nib[p*NIB_W +: NIB_W])
        );
    end
endmodule

// File: rtl/smii_gasket_chk.sv
module smii_gasket_chk
    import smii_gasket_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync,
    input logic [NUM_PORTS-1:0] tx_line,
    input logic [NUM_PORTS-1:0] rx_nib_vld,
    input logic [NUM_PORTS-1:0] rx_dv
);
    logic       seen;
    logic [4:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (sync) begin
            seen <= 1'b1;
            gap  <= 5'd1;
        end else if (gap != 5'd31) begin
            gap <= gap + 5'd1;
        end
    end

    p_sync_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && seen) |-> (gap == 5'(SEG_BITS)));

    p_sync_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gap == 5'(SEG_BITS)) |-> sync);

    p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && !sync) |-> (tx_line == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        p_nib_at_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_nib_vld[p]) |-> sync);

        p_nib_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_nib_vld[p]) |=> rx_nib_vld[p]);

        p_nib_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_nib_vld[p] && $past(rx_nib_vld[p])) |=> !rx_nib_vld[p]);

        p_nib_needs_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rx_nib_vld[p] |-> rx_dv[p]);
    end
endmodule

bind smii_gasket smii_gasket_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (smii_sync),
    .tx_line   (smii_tx),
    .rx_nib_vld(rx_nib_vld),
    .rx_dv     (rx_dv)
);

// File: tb/smii_gasket_test.sv
module smii_gasket_test;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_mode = 1'b0;
    logic          smii_sync;
    logic [NP-1:0] tx_nib_stb = '0;
    logic [NP*4-1:0] tx_nib = '0;
    logic [NP-1:0] tx_en = '0;
    logic [NP-1:0] tx_er = '0;
    logic [NP-1:0] smii_tx;
    logic [NP-1:0] smii_rx = '0;
    logic [NP-1:0] rx_crs, rx_dv, rx_nib_vld;
    logic [NP*4-1:0] rx_nib;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    logic [9:0] rx_drive [NP];
    logic [9:0] tx_seen  [NP];
    logic       feed_on  [NP];
    logic [7:0] feed_byte[NP];
    logic       feed_en  [NP];
    logic       feed_erl [NP];
    logic       feed_erh [NP];
    logic       cap_crs  [NP];
    logic       cap_dv   [NP];
    logic       cap_v0   [NP];
    logic       cap_v1   [NP];
    logic [3:0] cap_n0   [NP];
    logic [3:0] cap_n1   [NP];

    always #2.5 clk = ~clk;

    smii_gasket #(.NUM_PORTS(NP), .SLOW_REPEAT(10)) uut (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .smii_sync(smii_sync),
        .tx_nib_stb(tx_nib_stb), .tx_nib(tx_nib), .tx_en(tx_en), .tx_er(tx_er),
        .smii_tx(smii_tx), .smii_rx(smii_rx), .rx_crs(rx_crs), .rx_dv(rx_dv),
        .rx_nib_vld(rx_nib_vld), .rx_nib(rx_nib)
    );

    function automatic logic [9:0] seg(input logic [7:0] d, input logic b1, input logic b0);
        return {d, b1, b0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int p = 0; p < NP; p++) begin
            rx_drive[p] = '0;
            feed_on[p]  = 1'b0;
            feed_byte[p] = '0;
            feed_en[p]  = 1'b0;
            feed_erl[p] = 1'b0;
            feed_erh[p] = 1'b0;
        end
    endtask

    task automatic reset_dut(input logic slow);
        clear_stim();
        rst_n = 1'b0;
        slow_mode = slow;
        tx_nib_stb = '0; tx_nib = '0; tx_en = '0; tx_er = '0; smii_rx = '0;
        repeat (3) @(negedge clk);
        chk("R1", "sync in reset", smii_sync, 0);
        chk("R1", "tx lines in reset", smii_tx, 0);
        chk("R1", "rx outputs in reset", {rx_nib_vld, rx_crs, rx_dv}, 0);
        rst_n = 1'b1;
        #1;
        chk("R1", "sync before first edge", smii_sync, 0);
        chk("R1", "tx before first sync", smii_tx, 0);
        @(negedge clk);
        chk("R1", "first sync after first edge", smii_sync, 1);
    endtask

    // one segment: drive rx bits, sample tx bits, feed MAC nibbles, capture rx outputs
    task automatic do_segment();
        int tries = 0;
        int bad_sync = 0;
        while (smii_sync !== 1'b1 && tries < 30) begin
            @(negedge clk);
            tries++;
        end
        if (tries >= 30) chk("R2", "sync present", 0, 1);
        for (int b = 0; b < 10; b++) begin
            for (int p = 0; p < NP; p++) begin
                smii_rx[p]    = rx_drive[p][b];
                tx_seen[p][b] = smii_tx[p];
                if (b == 0) begin
                    cap_crs[p] = rx_crs[p];
                    cap_dv[p]  = rx_dv[p];
                    cap_v0[p]  = rx_nib_vld[p];
                    cap_n0[p]  = rx_nib[p*4 +: 4];
                end
                if (b == 1) begin
                    cap_v1[p] = rx_nib_vld[p];
                    cap_n1[p] = rx_nib[p*4 +: 4];
                end
                if (b == 3) begin
                    tx_nib_stb[p] = feed_on[p];
                    tx_nib[p*4 +: 4] = feed_byte[p][3:0];
                    tx_en[p] = feed_en[p];
                    tx_er[p] = feed_erl[p];
                end
                if (b == 4) begin
                    tx_nib_stb[p] = feed_on[p];
                    tx_nib[p*4 +: 4] = feed_byte[p][7:4];
                    tx_en[p] = feed_en[p];
                    tx_er[p] = feed_erh[p];
                end
                if (b == 5) begin
                    tx_nib_stb[p] = 1'b0;
                    tx_en[p] = 1'b0;
                    tx_er[p] = 1'b0;
                end
            end
            if (b != 0 && smii_sync !== 1'b0) bad_sync++;
            @(negedge clk);
        end
        chk("R2", "sync only on bit 0", bad_sync, 0);
        for (int p = 0; p < NP; p++) feed_on[p] = 1'b0;
    endtask

    task automatic t_reset_idle();
        reset_dut(1'b0);
        do_segment();
        for (int p = 0; p < NP; p++) chk("R5", "idle segment after reset", tx_seen[p], 0);
    endtask

    task automatic t_tx_order();
        reset_dut(1'b0);
        feed_on[0] = 1; feed_byte[0] = 8'hA5; feed_en[0] = 1;
        feed_on[1] = 1; feed_byte[1] = 8'h3C; feed_en[1] = 1; feed_erh[1] = 1;
        feed_on[2] = 1; feed_byte[2] = 8'h81; feed_en[2] = 1; feed_erl[2] = 1;
        do_segment();
        do_segment();
        chk("R3", "port0 segment bits", tx_seen[0], seg(8'hA5, 1, 0));
        chk("R4", "port1 high-nibble error", tx_seen[1], seg(8'h3C, 1, 1));
        chk("R4", "port2 low-nibble error", tx_seen[2], seg(8'h81, 1, 1));
        chk("R11", "port3 untouched", tx_seen[3], 0);
        do_segment();
        for (int p = 0; p < NP; p++) chk("R5", "no waiting byte gives zeros", tx_seen[p], 0);
    endtask

    task automatic t_rx_decode();
        reset_dut(1'b0);
        rx_drive[0] = seg(8'h5A, 1, 1);
        rx_drive[1] = seg(8'hC3, 0, 1);
        rx_drive[2] = seg(8'h0F, 1, 0);
        rx_drive[3] = '0;
        do_segment();
        clear_stim();
        rx_drive[0] = seg(8'h96, 1, 0);
        do_segment();
        chk("R6", "port0 crs/dv", {cap_crs[0], cap_dv[0]}, 2'b11);
        chk("R7", "port0 low nibble", {cap_v0[0], cap_n0[0]}, {1'b1, 4'hA});
        chk("R7", "port0 high nibble", {cap_v1[0], cap_n1[0]}, {1'b1, 4'h5});
        chk("R8", "port1 crs kept dv low", {cap_crs[1], cap_dv[1]}, 2'b10);
        chk("R8", "port1 no nibbles", {cap_v0[1], cap_v1[1]}, 2'b00);
        chk("R6", "port2 crs/dv", {cap_crs[2], cap_dv[2]}, 2'b01);
        chk("R7", "port2 nibbles", {cap_v0[2], cap_n0[2], cap_v1[2], cap_n1[2]},
            {1'b1, 4'hF, 1'b1, 4'h0});
        chk("R11", "port3 quiet", {cap_crs[3], cap_dv[3], cap_v0[3], cap_v1[3]}, 0);
        clear_stim();
        do_segment();
        chk("R7", "back-to-back segment nibbles", {cap_v0[0], cap_n0[0], cap_v1[0], cap_n1[0]},
            {1'b1, 4'h6, 1'b1, 4'h9});
        chk("R6", "port0 crs follows", {cap_crs[0], cap_dv[0]}, 2'b01);
        do_segment();
        chk("R8", "idle segment clears dv", {cap_dv[0], cap_v0[0], cap_v1[0]}, 0);
    endtask

    task automatic t_slow_tx();
        int bad = 0;
        reset_dut(1'b1);
        feed_on[0] = 1; feed_byte[0] = 8'h96; feed_en[0] = 1;
        do_segment();
        for (int k = 1; k < 10; k++) begin
            if (k == 2) begin feed_on[1] = 1; feed_byte[1] = 8'h11; feed_en[1] = 1; end
            if (k == 5) begin feed_on[1] = 1; feed_byte[1] = 8'h22; feed_en[1] = 1; end
            do_segment();
            for (int p = 0; p < NP; p++) if (tx_seen[p] !== 10'h0) bad++;
        end
        chk("R9", "segments 1-9 repeat idle", bad, 0);
        bad = 0;
        for (int k = 10; k < 20; k++) begin
            if (k == 12) begin feed_on[0] = 1; feed_byte[0] = 8'h44; feed_en[0] = 1; end
            do_segment();
            if (tx_seen[0] !== seg(8'h96, 1, 0)) bad++;
            if (tx_seen[1] !== seg(8'h22, 1, 0)) bad++;
        end
        chk("R9", "byte repeated over segments 10-19", bad, 0);
        chk("R4", "newer waiting byte replaced older", tx_seen[1], seg(8'h22, 1, 0));
        do_segment();
        chk("R9", "next byte at boundary 20", tx_seen[0], seg(8'h44, 1, 0));
        chk("R5", "port1 idle at boundary 20", tx_seen[1], 0);
    endtask

    task automatic t_slow_rx();
        int bad = 0;
        reset_dut(1'b1);
        rx_drive[0] = seg(8'h7E, 1, 1);
        do_segment();
        rx_drive[0] = seg(8'h11, 1, 0);
        do_segment();
        chk("R10", "segment 0 accepted", {cap_crs[0], cap_dv[0], cap_v0[0], cap_n0[0], cap_v1[0], cap_n1[0]},
            {1'b1, 1'b1, 1'b1, 4'hE, 1'b1, 4'h7});
        for (int k = 2; k <= 10; k++) begin
            if (k == 10) rx_drive[0] = seg(8'hB2, 1, 0);
            do_segment();
            if ({cap_crs[0], cap_dv[0], cap_v0[0], cap_v1[0]} !== 4'b1100) bad++;
        end
        chk("R10", "repeats 1-9 ignored", bad, 0);
        rx_drive[0] = '0;
        do_segment();
        chk("R10", "segment 10 accepted", {cap_crs[0], cap_dv[0], cap_v0[0], cap_n0[0], cap_v1[0], cap_n1[0]},
            {1'b0, 1'b1, 1'b1, 4'h2, 1'b1, 4'hB});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        t_reset_idle();
        t_tx_order();
        t_rx_decode();
        t_slow_tx();
        t_slow_rx();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule